// File: doc/BRIEF.md
# Interrupt pin delivery controller

This block sits between a set of interrupt input pins and the processor-local interrupt controllers. Each pin has a 64-bit routing entry, held in a table outside the block and presented on a flat input bus. Devices drive per-pin assert, deassert and pulse commands. The block keeps a signed assertion count for every pin. It raises a delivery request only when that count goes from zero to one. Pending requests are serviced one at a time and turned into messages that carry a vector, a destination CPU index and a level flag.

Level-triggered entries set a remote-IRR bit when they deliver. The block owns these bits and exports them. An end-of-interrupt strobe carries a vector and starts a scan that visits one pin per clock. The scan clears the matching remote-IRR bits and re-delivers any pin that is still asserted. When software rewrites an entry, a write strobe names the pin, so that an already asserted pin can deliver once it has been unmasked. A destination of all ones fans the message out to every active CPU.

Top module: `irq_pin_router`

## Requirements
- R1: A pin's count rises by one on an assert command (op 2'b00) and falls by one on a deassert command (op 2'b01). Only an assert that finds the count at zero requests a delivery, so a second assert on a pin that is already asserted produces no message. Op 2'b11 has no effect.
- R2: A pulse command (op 2'b10) acts as an assert followed at once by a deassert. It requests a delivery when the count was zero and leaves the count unchanged.
- R3: A command whose pin number is NPINS or above raises `cmd_bad_pin` one cycle later and changes no pin's count. A command with a valid pin number leaves `cmd_bad_pin` low.
- R4: A deassert that finds the count at zero or below, or a pulse that finds it below zero, raises `cnt_underflow` one cycle later. The count still moves, and a pin brought back up to zero from below by an assert does not deliver.
- R5: A serviced request sends nothing when the entry has logical destination mode (bit 11 set), a delivery mode other than fixed (bits 10:8 not zero), or its mask (bit 16) set.
- R6: A delivery from a level entry (bit 15 set) sets that pin's bit on `rirr`. A delivery from an edge entry leaves `rirr` unchanged.
- R7: The message vector is entry bits 7:0 and the level flag is entry bit 15. For a unicast delivery, `msg_cpu` is entry bits 63:56.
- R8: A destination of 8'hFF sends one message to each set bit of `cpu_active`, lowest index first.
- R9: An accepted EOI holds `eoi_busy` high for exactly NPINS cycles. During that time, every pin with its `rirr` bit set and a vector equal to the EOI vector has its bit cleared, and is delivered again if its count is above zero.
- R10: An entry-write strobe requests a delivery when that entry is unmasked, its `rirr` bit is clear and its count is above zero. Otherwise it requests nothing.
- R11: When several pins are pending at once, they are serviced in ascending pin order.
- R12: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and the vector, CPU and level fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Pin command strobe |
| cmd_op | input | 2 | 00 assert, 01 deassert, 10 pulse, 11 none |
| cmd_pin | input | PINW | Pin addressed by the command |
| cmd_bad_pin | output | 1 | Previous command named a pin out of range |
| cnt_underflow | output | 1 | Previous command drove a count below zero |
| ent_cfg | input | NPINS x 64 | Routing entries, one per pin |
| ent_wr_valid | input | 1 | An entry has just been rewritten |
| ent_wr_pin | input | PINW | Pin whose entry was rewritten |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being acknowledged |
| eoi_busy | output | 1 | EOI scan in progress |
| rirr | output | NPINS | Remote-IRR bit of each pin |
| cpu_active | input | NCPU | Active CPUs, used for broadcast |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vec | output | 8 | Interrupt vector |
| msg_cpu | output | 8 | Destination CPU index |
| msg_level | output | 1 | Level-triggered flag |

## Verification
The checks assume that an EOI strobe arrives only while `eoi_busy` is low, because a strobe during a scan is not queued. They also assume that no pin count is driven past its signed range, and that an entry does not change while its pin is being delivered. The directed stimulus waits for each scan to finish before it sends the next EOI. It keeps every count within a few steps of zero, and it writes entries only while the message path is idle.

// File: rtl/irq_pin_router.sv
module irq_pin_router #(
  parameter int NPINS = 24,
  parameter int NCPU  = 8,
  parameter int CNTW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(NPINS)-1:0]   cmd_pin,
  output logic                       cmd_bad_pin,
  output logic                       cnt_underflow,
  input  logic [NPINS-1:0][63:0]     ent_cfg,
  input  logic                       ent_wr_valid,
  input  logic [$clog2(NPINS)-1:0]   ent_wr_pin,
  input  logic                       eoi_valid,
  input  logic [7:0]                 eoi_vec,
  output logic                       eoi_busy,
  output logic [NPINS-1:0]           rirr,
  input  logic [NCPU-1:0]            cpu_active,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic [7:0]                 msg_vec,
  output logic [7:0]                 msg_cpu,
  output logic                       msg_level
);
  localparam int PINW = $clog2(NPINS);
  localparam logic [PINW:0] PIN_LIM = (PINW+1)'(NPINS);
  localparam logic [1:0] OP_ASSERT = 2'b00, OP_DEASSERT = 2'b01, OP_PULSE = 2'b10;

  typedef enum logic {S_IDLE, S_SEND} state_t;

  logic [CNTW-1:0]  cnt [NPINS];
  logic [NPINS-1:0] req_q, rirr_q, poscnt, fire_cmd, fire_wr, eoi_hit, take, set_lvl;
  logic [CNTW-1:0]  sel_cnt;
  logic [PINW-1:0]  pick, scan_idx;
  logic [63:0]      pick_ent;
  logic [7:0]       scan_vec;
  logic [NCPU-1:0]  bc_left, bc_rest;
  logic             pin_ok, cmd_ok, wr_ok, has_req, drop, bcast, bc_mode, busy_q, underflow_n;
  logic             unused_bits;
  state_t           state;

  function automatic logic [7:0] low_idx(input logic [NCPU-1:0] m);
    logic [7:0] r;
    r = '0;
    for (int i = NCPU-1; i >= 0; i--)
      if (m[i]) r = 8'(i);
    return r;
  endfunction

  assign pin_ok = {1'b0, cmd_pin} < PIN_LIM;
  assign cmd_ok = cmd_valid && pin_ok;
  assign wr_ok  = ent_wr_valid && ({1'b0, ent_wr_pin} < PIN_LIM);

  always_comb begin
    sel_cnt     = '0;
    unused_bits = 1'b0;
    for (int p = 0; p < NPINS; p++) begin
      poscnt[p]   = !cnt[p][CNTW-1] && (cnt[p] != '0);
      if (cmd_pin == PINW'(p)) sel_cnt = cnt[p];
      fire_cmd[p] = cmd_ok && (cmd_pin == PINW'(p)) && (cnt[p] == '0) &&
                    (cmd_op == OP_ASSERT || cmd_op == OP_PULSE);
      fire_wr[p]  = wr_ok && (ent_wr_pin == PINW'(p)) && !ent_cfg[p][16] &&
                    !rirr_q[p] && poscnt[p];
      eoi_hit[p]  = busy_q && (scan_idx == PINW'(p)) && rirr_q[p] &&
                    (ent_cfg[p][7:0] == scan_vec);
      unused_bits = unused_bits ^ (^ent_cfg[p][55:17]) ^ (^ent_cfg[p][14:12]);
    end
  end

  always_comb begin
    pick = '0;
    for (int p = NPINS-1; p >= 0; p--)
      if (req_q[p]) pick = PINW'(p);
  end

  always_comb begin
    pick_ent = '0;
    for (int p = 0; p < NPINS; p++)
      if (pick == PINW'(p)) pick_ent = ent_cfg[p];
  end

  assign has_req = |req_q;
  assign drop    = pick_ent[11] | (|pick_ent[10:8]) | pick_ent[16];
  assign bcast   = pick_ent[63:56] == 8'hFF;
  assign take    = (state == S_IDLE && has_req) ? (NPINS'(1) << pick) : '0;
  assign set_lvl = (state == S_IDLE && has_req && !drop && pick_ent[15]) ?
                   (NPINS'(1) << pick) : '0;
  assign bc_rest = bc_left & (bc_left - NCPU'(1));

  assign underflow_n = cmd_ok &&
    ((cmd_op == OP_DEASSERT && (sel_cnt[CNTW-1] || sel_cnt == '0)) ||
     (cmd_op == OP_PULSE && sel_cnt[CNTW-1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) cnt[p] <= '0;
    end else begin
      for (int p = 0; p < NPINS; p++)
        if (cmd_ok && cmd_pin == PINW'(p)) begin
          if (cmd_op == OP_ASSERT)        cnt[p] <= cnt[p] + CNTW'(1);
          else if (cmd_op == OP_DEASSERT) cnt[p] <= cnt[p] - CNTW'(1);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q         <= '0;
      rirr_q        <= '0;
      cmd_bad_pin   <= 1'b0;
      cnt_underflow <= 1'b0;
    end else begin
      req_q         <= (req_q & ~take) | fire_cmd | fire_wr | (eoi_hit & poscnt);
      rirr_q        <= (rirr_q & ~eoi_hit) | set_lvl;
      cmd_bad_pin   <= cmd_valid && !pin_ok;
      cnt_underflow <= underflow_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      scan_idx <= '0;
      scan_vec <= '0;
    end else if (!busy_q) begin
      if (eoi_valid) begin
        busy_q   <= 1'b1;
        scan_idx <= '0;
        scan_vec <= eoi_vec;
      end
    end else begin
      scan_idx <= scan_idx + PINW'(1);
      if (scan_idx == PINW'(NPINS-1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bc_left   <= '0;
      bc_mode   <= 1'b0;
      msg_vec   <= '0;
      msg_cpu   <= '0;
      msg_level <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (has_req && !drop) begin
            msg_vec   <= pick_ent[7:0];
            msg_level <= pick_ent[15];
            bc_mode   <= bcast;
            if (bcast) begin
              if (|cpu_active) begin
                bc_left <= cpu_active;
                msg_cpu <= low_idx(cpu_active);
                state   <= S_SEND;
              end
            end else begin
              msg_cpu <= pick_ent[63:56];
              state   <= S_SEND;
            end
          end
        S_SEND:
          if (msg_ready) begin
            if (bc_mode && |bc_rest) begin
              bc_left <= bc_rest;
              msg_cpu <= low_idx(bc_rest);
            end else begin
              state <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign msg_valid = state == S_SEND;
  assign eoi_busy  = busy_q;
  assign rirr      = rirr_q;
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
  parameter int NPINS = 24,
  parameter int CNTW  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_op,
  input logic [$clog2(NPINS)-1:0] cmd_pin,
  input logic                     cmd_bad_pin,
  input logic                     cnt_underflow,
  input logic [CNTW-1:0]          sel_cnt,
  input logic                     eoi_valid,
  input logic                     eoi_busy,
  input logic                     msg_valid,
  input logic                     msg_ready,
  input logic [7:0]               msg_vec,
  input logic [7:0]               msg_cpu,
  input logic                     msg_level
);
  localparam int PINW = $clog2(NPINS);
  localparam logic [PINW:0] LIM = (PINW+1)'(NPINS);

  logic [7:0] busy_run;
  logic       bad;

  assign bad = {1'b0, cmd_pin} >= LIM;

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_run <= '0;
    else if (eoi_busy) busy_run <= busy_run + 8'd1;
    else               busy_run <= '0;
  end

  p_bad_pin_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && bad |=> cmd_bad_pin);

  p_good_pin_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && bad) |=> !cmd_bad_pin);

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !bad && cmd_op == 2'b01 && (sel_cnt[CNTW-1] || sel_cnt == '0)
    |=> cnt_underflow);

  p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vec) &&
    $stable(msg_cpu) && $stable(msg_level));

  p_eoi_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !eoi_busy |=> eoi_busy);

  p_eoi_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoi_busy) |-> busy_run == 8'(NPINS));
endmodule

bind irq_pin_router irq_pin_router_chk #(.NPINS(NPINS), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_pin(cmd_pin), .cmd_bad_pin(cmd_bad_pin), .cnt_underflow(cnt_underflow),
  .sel_cnt(sel_cnt), .eoi_valid(eoi_valid), .eoi_busy(eoi_busy),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vec(msg_vec),
  .msg_cpu(msg_cpu), .msg_level(msg_level));

// File: tb/irq_pin_router_tb.sv
`timescale 1ns/1ps
module irq_pin_router_tb;
  localparam int NP = 24;
  localparam logic [1:0] A = 2'b00, D = 2'b01, P = 2'b10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, ent_wr_valid = 0, eoi_valid = 0, msg_ready = 1;
  logic [1:0] cmd_op = 0;
  logic [4:0] cmd_pin = 0, ent_wr_pin = 0;
  logic [NP-1:0][63:0] ent;
  logic [7:0] eoi_vec = 0, msg_vec, msg_cpu;
  logic [7:0] cpu_active = 8'b1010_0110;
  logic cmd_bad_pin, cnt_underflow, eoi_busy, msg_valid, msg_level;
  logic [NP-1:0] rirr;

  int nchk = 0, nerr = 0, nmsg = 0;
  logic [7:0] lvec [32];
  logic [7:0] lcpu [32];
  logic       llvl [32];

  always #4 clk = ~clk;

  irq_pin_router u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pin(cmd_pin), .cmd_bad_pin(cmd_bad_pin), .cnt_underflow(cnt_underflow),
    .ent_cfg(ent), .ent_wr_valid(ent_wr_valid), .ent_wr_pin(ent_wr_pin),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .eoi_busy(eoi_busy), .rirr(rirr),
    .cpu_active(cpu_active), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vec(msg_vec), .msg_cpu(msg_cpu), .msg_level(msg_level));

  always @(negedge clk)
    if (rst_n && msg_valid && msg_ready && nmsg < 32) begin
      lvec[nmsg] = msg_vec; lcpu[nmsg] = msg_cpu; llvl[nmsg] = msg_level;
      nmsg++;
    end

  function automatic logic [63:0] mk(input logic [7:0] v, input logic lvl,
                                     input logic msk, input logic [7:0] dst);
    logic [63:0] e;
    e = '0; e[7:0] = v; e[15] = lvl; e[16] = msk; e[63:56] = dst;
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [4:0] pin);
    @(posedge clk); #1 cmd_valid = 1; cmd_op = op; cmd_pin = pin;
    @(posedge clk); #1 cmd_valid = 0;
  endtask

  task automatic entwr(input int pin, input logic [63:0] v);
    @(posedge clk); #1 ent[pin] = v; ent_wr_valid = 1; ent_wr_pin = 5'(pin);
    @(posedge clk); #1 ent_wr_valid = 0;
  endtask

  task automatic eoi(input logic [7:0] v, output int busy_cycles);
    @(posedge clk); #1 eoi_valid = 1; eoi_vec = v;
    @(posedge clk); #1 eoi_valid = 0;
    busy_cycles = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (eoi_busy) busy_cycles++; else break;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("reset msg_valid", msg_valid, 0);
    check("reset eoi_busy", eoi_busy, 0);
    check("reset rirr", rirr, 0);
    check("reset flags", {cmd_bad_pin, cnt_underflow}, 0);
  endtask

  task automatic t_unicast;
    ent[3] = mk(8'h33, 0, 0, 8'd5);
    nmsg = 0; cmd(A, 3); settle(10);
    check("R1 first assert delivers", nmsg, 1);
    check("R7 vector", lvec[0], 8'h33);
    check("R7 unicast cpu", lcpu[0], 8'd5);
    check("R7 level flag edge", llvl[0], 0);
    check("R6 edge leaves rirr", rirr[3], 0);
    nmsg = 0; cmd(A, 3); settle(10);
    check("R1 second assert silent", nmsg, 0);
    cmd(D, 3); cmd(D, 3); nmsg = 0; cmd(A, 3); settle(10);
    check("R1 re-assert after release", nmsg, 1);
    nmsg = 0; cmd(2'b11, 3); settle(6);
    check("R1 op 11 no effect", nmsg, 0);
    cmd(D, 3);
  endtask

  task automatic t_pulse;
    ent[4] = mk(8'h44, 0, 0, 8'd1);
    nmsg = 0; cmd(P, 4); settle(10);
    check("R2 pulse delivers", nmsg, 1);
    check("R2 pulse vector", lvec[0], 8'h44);
    nmsg = 0; cmd(A, 4); settle(10);
    check("R2 count back to zero", nmsg, 1);
    cmd(D, 4);
  endtask

  task automatic t_bad_pin;
    ent[0] = mk(8'h0A, 0, 0, 8'd2);
    ent[8] = mk(8'h0B, 0, 0, 8'd2);
    nmsg = 0; cmd(A, 5'd24); @(negedge clk);
    check("R3 bad pin flag", cmd_bad_pin, 1);
    cmd(A, 5'd31); @(negedge clk);
    check("R3 bad pin flag 31", cmd_bad_pin, 1);
    settle(8);
    check("R3 bad pin no message", nmsg, 0);
    cmd(A, 0); @(negedge clk);
    check("R3 good pin flag low", cmd_bad_pin, 0);
    cmd(A, 8); settle(12);
    check("R3 aliases untouched", nmsg, 2);
    cmd(D, 0); cmd(D, 8);
    ent[0] = mk(0, 0, 1, 0); ent[8] = mk(0, 0, 1, 0);
  endtask

  task automatic t_underflow;
    ent[5] = mk(8'h55, 0, 0, 8'd0);
    nmsg = 0; cmd(D, 5); @(negedge clk);
    check("R4 underflow flag", cnt_underflow, 1);
    cmd(A, 5); @(negedge clk);
    check("R4 assert clears flag", cnt_underflow, 0);
    settle(8);
    check("R4 -1 to 0 no delivery", nmsg, 0);
    cmd(A, 5); settle(10);
    check("R4 0 to 1 delivers", nmsg, 1);
    cmd(D, 5); @(negedge clk);
    check("R4 1 to 0 no flag", cnt_underflow, 0);
  endtask

  task automatic t_drop;
    ent[6] = mk(8'h66, 0, 1, 8'd0);
    ent[7] = mk(8'h77, 0, 0, 8'd0) | 64'h800;
    ent[8] = mk(8'h88, 0, 0, 8'd0) | 64'h100;
    nmsg = 0; cmd(A, 6); cmd(A, 7); cmd(A, 8); settle(10);
    check("R5 masked/logical/nonfixed dropped", nmsg, 0);
    entwr(6, mk(8'h66, 0, 0, 8'd4)); settle(10);
    check("R10 unmask write delivers", nmsg, 1);
    check("R10 unmask vector", lvec[0], 8'h66);
    cmd(D, 6); cmd(D, 7); cmd(D, 8);
  endtask

  task automatic t_level;
    int bc;
    ent[9] = mk(8'h50, 1, 0, 8'd2);
    nmsg = 0; cmd(A, 9); settle(10);
    check("R6 level delivers", nmsg, 1);
    check("R7 level flag", llvl[0], 1);
    check("R6 rirr set", rirr[9], 1);
    nmsg = 0; entwr(9, mk(8'h50, 1, 0, 8'd2)); settle(10);
    check("R10 rirr blocks write delivery", nmsg, 0);
    eoi(8'h51, bc); settle(4);
    check("R9 other vector keeps rirr", rirr[9], 1);
    check("R9 other vector no message", nmsg, 0);
    eoi(8'h50, bc);
    check("R9 busy length", bc, NP);
    settle(10);
    check("R9 redelivery", nmsg, 1);
    check("R9 rirr set again", rirr[9], 1);
    cmd(D, 9); nmsg = 0; eoi(8'h50, bc); settle(10);
    check("R9 rirr cleared", rirr[9], 0);
    check("R9 released pin silent", nmsg, 0);
  endtask

  task automatic t_broadcast;
    ent[11] = mk(8'h60, 0, 0, 8'hFF);
    nmsg = 0; cmd(A, 11); settle(20);
    check("R8 broadcast count", nmsg, 4);
    check("R8 cpu order 0", lcpu[0], 8'd1);
    check("R8 cpu order 1", lcpu[1], 8'd2);
    check("R8 cpu order 2", lcpu[2], 8'd5);
    check("R8 cpu order 3", lcpu[3], 8'd7);
    cmd(D, 11);
  endtask

  task automatic t_arb;
    for (int p = 12; p < 16; p++) ent[p] = mk(8'hC0 + 8'(p), 0, 0, 8'd3);
    nmsg = 0;
    @(posedge clk); #1 msg_ready = 0;
    cmd(A, 15); settle(4);
    cmd(A, 14); cmd(A, 13); cmd(A, 12);
    @(negedge clk);
    check("R12 valid held", msg_valid, 1);
    check("R12 first vector", msg_vec, 8'hCF);
    settle(5);
    check("R12 vector stable", msg_vec, 8'hCF);
    @(posedge clk); #1 msg_ready = 1;
    settle(20);
    check("R11 count", nmsg, 4);
    check("R11 order 0", lvec[0], 8'hCF);
    check("R11 order 1", lvec[1], 8'hCC);
    check("R11 order 2", lvec[2], 8'hCD);
    check("R11 order 3", lvec[3], 8'hCE);
    for (int p = 12; p < 16; p++) cmd(D, 5'(p));
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) ent[p] = mk(8'h00, 0, 1, 8'h00);
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_unicast();
    t_pulse();
    t_bad_pin();
    t_underflow();
    t_drop();
    t_level();
    t_broadcast();
    t_arb();
    finish_run();
  end
endmodule